// File: doc/BRIEF.md
# Rewindable FIFO Buffer with Occupancy Flags

This block is a single-clock first-in first-out store for 9-bit words. Its depth is set by a parameter, and the depth must be a power of two. A producer writes one word for each low pulse on an active-low write strobe. A consumer reads one word for each low pulse on an active-low read strobe. Both strobes are sampled on the system clock, and only a high-to-low change starts an access. The output-enable is high only while the read strobe is low, so board logic can put the data bus into high impedance at all other times.

Three flags report the fill level: empty, full, and more than half full. A write made while the buffer is full is discarded, and so is a read made while it is empty. A rewind input returns the read side to the first word written since reset. The stored contents do not change, so a consumer can fetch a packet a second time. An asynchronous active-low master reset clears everything. Its release is synchronised inside the block.

Top module: `fifo_rt`

## Requirements
- R1: Words leave on `data_out` in the order in which they were accepted.
- R2: A write is accepted once per high-to-low change of `wr_strobe_n` seen on the clock, however long the strobe stays low. The word on `data_in` in that cycle is stored.
- R3: A read takes effect in the clock cycle in which `rd_strobe_n` is first sampled low. The word appears on `data_out` after that edge and holds until the next accepted read.
- R4: `out_en` is 1 exactly while `rd_strobe_n` is 0.
- R5: A write made while `flag_full` is 1 changes neither the stored words nor the occupancy.
- R6: A read made while `flag_empty` is 1 leaves `data_out` and the occupancy unchanged.
- R7: `flag_empty` is 1 exactly when the occupancy is 0.
- R8: `flag_full` is 1 exactly when the occupancy equals DEPTH.
- R9: `flag_half` is 1 exactly when the occupancy is at least DEPTH/2+1.
- R10: `rewind_n` sampled 0 while both strobes are 1 sets the next read to the first word written since reset. It sets the occupancy to the number of writes since reset, capped at DEPTH, and leaves the stored data unchanged.
- R11: `rewind_n` has no effect in a cycle in which either strobe is sampled 0.
- R12: While `rst_n` is 0, `flag_empty` is 1, `flag_full` and `flag_half` are 0, and `data_out` is 0. The block resumes work two clock edges after `rst_n` rises.
- R13: When read and write edges fall in the same cycle, both are carried out and the occupancy is unchanged. If the buffer is empty, only the write is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| wr_strobe_n | input | 1 | Active-low write strobe; one word is stored per low pulse |
| rd_strobe_n | input | 1 | Active-low read strobe; one word is fetched per low pulse |
| rewind_n | input | 1 | Active-low rewind of the read side to the first word |
| data_in | input | 9 | Word to be written |
| data_out | output | 9 | Last word read |
| out_en | output | 1 | High while the read strobe is low; low means high impedance |
| flag_empty | output | 1 | Occupancy is zero |
| flag_full | output | 1 | Occupancy equals DEPTH |
| flag_half | output | 1 | Occupancy is at least DEPTH/2+1 |

## Verification
The properties assume that a flag can change only through a sampled strobe level or a rewind request. They also assume that the data output can move only in a cycle in which the read strobe is low. So the stimulus changes strobes, data and rewind only on the falling clock edge. Each strobe is raised again for at least one cycle between accesses, so that every intended access gives one clean high-to-low change. Rewind is pulsed with both strobes high, except in the one case that checks the rewind is ignored while a read is in progress.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int unsigned WORD_W = 9;

  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } fill_flags_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_WRITE = 2'b10,
    ACC_READ  = 2'b01,
    ACC_BOTH  = 2'b11
  } access_e;
endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fifo_rt_edge.sv
module fifo_rt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  // a new low pulse is one whose previous sample was high
  assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/fifo_rt_ram.sv
module fifo_rt_ram #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb rdata_d = re ? mem[raddr] : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fall,
  input  logic              rd_fall,
  input  logic              wr_level_n,
  input  logic              rd_level_n,
  input  logic              rewind_n,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output fill_flags_t       flags
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0]  HALF_CNT  = CNT_W'(DEPTH / 2 + 1);

  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [ADDR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic              wrap_q, wrap_d;
  logic              rewind_go;
  access_e           acc;

  always_comb begin
    flags.empty = (cnt_q == '0);
    flags.full  = (cnt_q == FULL_CNT);
    flags.half  = (cnt_q >= HALF_CNT);
  end

  always_comb begin
    wr_go     = wr_fall & ~flags.full;
    rd_go     = rd_fall & ~flags.empty;
    rewind_go = ~rewind_n & wr_level_n & rd_level_n;
    acc       = access_e'({wr_go, rd_go});
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (wr_go) begin
      wptr_d = wptr_q + ADDR_W'(1);
      if (wptr_q == LAST_ADDR) wrap_d = 1'b1;
    end
    if (rewind_go) begin
      rptr_d = '0;
      cnt_d  = wrap_q ? FULL_CNT : {1'b0, wptr_q};
    end else begin
      if (rd_go) rptr_d = rptr_q + ADDR_W'(1);
      unique case (acc)
        ACC_WRITE: cnt_d = cnt_q + CNT_W'(1);
        ACC_READ:  cnt_d = cnt_q - CNT_W'(1);
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign waddr = wptr_q;
  assign raddr = rptr_q;
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned ADDR_W  = $clog2(DEPTH),
  localparam int unsigned NSTROBE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe_n,
  input  logic              rd_strobe_n,
  input  logic              rewind_n,
  input  logic [WORD_W-1:0] data_in,
  output logic [WORD_W-1:0] data_out,
  output logic              out_en,
  output logic              flag_empty,
  output logic              flag_full,
  output logic              flag_half
);
  logic               rst_n_int;
  logic [NSTROBE-1:0] strobes_n;
  logic [NSTROBE-1:0] falls;
  logic               wr_go, rd_go;
  logic [ADDR_W-1:0]  waddr, raddr;
  fill_flags_t        flags;

  fifo_rt_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // index 0 is the write strobe, index 1 the read strobe
  assign strobes_n = {rd_strobe_n, wr_strobe_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_edge
    fifo_rt_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .strobe_n (strobes_n[g]),
      .fall     (falls[g])
    );
  end

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_fall    (falls[0]),
    .rd_fall    (falls[1]),
    .wr_level_n (wr_strobe_n),
    .rd_level_n (rd_strobe_n),
    .rewind_n   (rewind_n),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .waddr      (waddr),
    .raddr      (raddr),
    .flags      (flags)
  );

  fifo_rt_ram #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (wr_go),
    .waddr (waddr),
    .wdata (data_in),
    .re    (rd_go),
    .raddr (raddr),
    .rdata (data_out)
  );

  assign out_en     = ~rd_strobe_n;
  assign flag_empty = flags.empty;
  assign flag_full  = flags.full;
  assign flag_half  = flags.half;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_strobe_n,
  input logic              rd_strobe_n,
  input logic              rewind_n,
  input logic [DATA_W-1:0] data_out,
  input logic              flag_empty,
  input logic              flag_full,
  input logic              flag_half
);
  assert_empty_full_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_empty && flag_full));

  assert_full_implies_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |-> flag_half);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_full && rd_strobe_n && rewind_n) |=> flag_full);

  assert_no_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_empty && wr_strobe_n && rewind_n) |=> flag_empty);

  assert_output_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_n |=> $stable(data_out));

  assert_half_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_half) |-> ($past(!wr_strobe_n) || $past(!rewind_n)));

  assert_empty_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_empty) |-> ($past(!wr_strobe_n) || $past(!rewind_n)));
endmodule

bind fifo_rt fifo_rt_chk #(.DATA_W(fifo_rt_pkg::WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_strobe_n (wr_strobe_n),
  .rd_strobe_n (rd_strobe_n),
  .rewind_n    (rewind_n),
  .data_out    (data_out),
  .flag_empty  (flag_empty),
  .flag_full   (flag_full),
  .flag_half   (flag_half)
);

// File: tb/fifo_rt_bench.sv
`timescale 1ns/1ps
module fifo_rt_bench;
  localparam int unsigned DEPTH = 8;
  localparam int NVEC = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_strobe_n, rd_strobe_n, rewind_n;
  logic [8:0] data_in;
  logic [8:0] data_out;
  logic       out_en, flag_empty, flag_full, flag_half;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  fifo_rt #(.DEPTH(DEPTH)) u_fifo_rt (
    .clk(clk), .rst_n(rst_n), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
    .rewind_n(rewind_n), .data_in(data_in), .data_out(data_out), .out_en(out_en),
    .flag_empty(flag_empty), .flag_full(flag_full), .flag_half(flag_half)
  );

  // entry: {op[1:0] (bit0 write, bit1 read), din[8:0], check_q, q[8:0], {empty,full,half}}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd1, 9'h101, 1'b0, 9'h000, 3'b000},
    {2'd1, 9'h0A2, 1'b0, 9'h000, 3'b000},
    {2'd2, 9'h000, 1'b1, 9'h101, 3'b000},
    {2'd3, 9'h033, 1'b1, 9'h0A2, 3'b000},  // R13 both edges
    {2'd1, 9'h144, 1'b0, 9'h000, 3'b000},
    {2'd1, 9'h055, 1'b0, 9'h000, 3'b000},
    {2'd1, 9'h1E6, 1'b0, 9'h000, 3'b000},
    {2'd1, 9'h077, 1'b0, 9'h000, 3'b001},  // R9 reaches DEPTH/2+1
    {2'd1, 9'h188, 1'b0, 9'h000, 3'b001},
    {2'd1, 9'h099, 1'b0, 9'h000, 3'b001},
    {2'd1, 9'h1AA, 1'b0, 9'h000, 3'b011},  // R8 full
    {2'd1, 9'h1FF, 1'b0, 9'h000, 3'b011},  // R5 write while full
    {2'd2, 9'h000, 1'b1, 9'h033, 3'b001},
    {2'd2, 9'h000, 1'b1, 9'h144, 3'b001},
    {2'd2, 9'h000, 1'b1, 9'h055, 3'b001},
    {2'd2, 9'h000, 1'b1, 9'h1E6, 3'b000},  // R9 below mark
    {2'd3, 9'h011, 1'b1, 9'h077, 3'b000},
    {2'd2, 9'h000, 1'b1, 9'h188, 3'b000},
    {2'd2, 9'h000, 1'b1, 9'h099, 3'b000},
    {2'd2, 9'h000, 1'b1, 9'h1AA, 3'b000},
    {2'd2, 9'h000, 1'b1, 9'h011, 3'b100},  // R7 empty
    {2'd2, 9'h000, 1'b1, 9'h011, 3'b100},  // R6 read while empty
    {2'd3, 9'h0C3, 1'b1, 9'h011, 3'b000},  // R13 empty: write only
    {2'd2, 9'h000, 1'b1, 9'h0C3, 3'b100}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic [2:0] efh);
    check({req, " empty"}, int'(flag_empty), int'(efh[2]));
    check({req, " full"},  int'(flag_full),  int'(efh[1]));
    check({req, " half"},  int'(flag_half),  int'(efh[0]));
  endtask

  task automatic start_op(input logic [1:0] op, input logic [8:0] d);
    @(negedge clk);
    data_in     = d;
    wr_strobe_n = ~op[0];
    rd_strobe_n = ~op[1];
    @(negedge clk);
  endtask

  task automatic end_op();
    wr_strobe_n = 1'b1;
    rd_strobe_n = 1'b1;
    @(negedge clk);
    check("R4 idle out_en", int'(out_en), 0);
  endtask

  task automatic read_expect(input string req, input logic [8:0] q, input logic [2:0] efh);
    start_op(2'd2, 9'h000);
    check({req, " data"}, int'(data_out), int'(q));
    check("R4 out_en", int'(out_en), 1);
    check_flags(req, efh);
    end_op();
  endtask

  task automatic write_word(input logic [8:0] d);
    start_op(2'd1, d);
    end_op();
  endtask

  task automatic rewind_pulse(input string req, input logic [2:0] efh);
    @(negedge clk);
    rewind_n = 1'b0;
    @(negedge clk);
    rewind_n = 1'b1;
    check_flags(req, efh);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_flags("R12 reset", 3'b100);
    check("R12 reset data", int'(data_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_flags("R12 after release", 3'b100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_strobe_n = 1'b1;
    rd_strobe_n = 1'b1;
    rewind_n = 1'b1;
    data_in = '0;
    do_reset();

    // table walk: R1 order, R2 writes, R3 reads, R5..R9, R13
    for (int i = 0; i < NVEC; i++) begin
      start_op(VEC[i][23:22], VEC[i][21:13]);
      if (VEC[i][12]) check("R1 R3 data", int'(data_out), int'(VEC[i][11:3]));
      if (VEC[i][23]) check("R4 out_en", int'(out_en), 1);
      check_flags("R7 R8 R9 table", VEC[i][2:0]);
      end_op();
    end

    // R12 reset mid-run, then rewind on an empty buffer stays empty (R10)
    write_word(9'h1C1);
    do_reset();
    rewind_pulse("R10 rewind none written", 3'b100);

    // R10: rewind returns to first word with occupancy restored
    write_word(9'h0A1);
    write_word(9'h0B2);
    write_word(9'h0C3);
    read_expect("R1", 9'h0A1, 3'b000);
    read_expect("R1", 9'h0B2, 3'b000);
    rewind_pulse("R10 rewind", 3'b000);
    read_expect("R10 first again", 9'h0A1, 3'b000);

    // R11: rewind while the read strobe is low is ignored
    @(negedge clk);
    rd_strobe_n = 1'b0;
    rewind_n = 1'b0;
    @(negedge clk);
    rewind_n = 1'b1;
    check("R11 read during rewind", int'(data_out), 9'h0B2);
    end_op();
    read_expect("R11 no rewind", 9'h0C3, 3'b100);

    // R2: a long low pulse stores one word only
    @(negedge clk);
    data_in = 9'h155;
    wr_strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    check_flags("R2 long pulse", 3'b000);
    end_op();
    read_expect("R2 single word", 9'h155, 3'b100);
    read_expect("R6 empty read", 9'h155, 3'b100);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule